// File: doc/BRIEF.md
# Matrix Keypad Scanner with Snapshot FIFO

The block scans a key matrix of up to 16 rows and 8 columns. Paced by a slow scan tick, it pulls one row low at a time, waits a fixed settle time, and then watches the active-low column lines for a programmable number of ticks. A key is accepted only if its column level held steady over that whole debounce window. When the last row of a pass is done, every accepted key is packed into a byte entry with a valid flag, its row and its column. Up to eight entries make a 64-bit snapshot, which is pushed into a small FIFO if at least one key was seen.

Software reads the oldest snapshot through two 32-bit entry registers. Reading the upper word pops the snapshot. A status register gives the FIFO fill level, a sticky threshold flag and a sticky wake flag. An interrupt output follows the threshold flag when it is enabled. Each row has its own mask register, and clearing a column bit in it lets that key raise the wake flag. While keys stay held, scan passes repeat after a programmable gap, so the FIFO keeps filling.

Top module: `keypad_scan_top`

## Requirements
- R1: After reset, all row outputs are high, irq_o and wake_o are low, and the control, status and entry registers read 0. Every row mask register reads 0xFF (all keys masked).
- R2: At most one row output is low at any time. The active row steps 0,1,2,...,NUM_ROWS-1 within each pass.
- R3: A pass is 5 start ticks, then NUM_ROWS row windows of (16 + debounce) ticks each, then repeat-gap ticks (register 0x2C). With the key set held and the tick always high, successive snapshot pushes are therefore 5 + NUM_ROWS*(16+debounce) + gap clocks apart.
- R4: A key entry is a byte: bit 7 is valid, bits 6:3 are the row and bits 2:0 are the column. Entries 0..3 are in register 0x30 and entries 4..7 in register 0x34, lowest byte first. Unused entries are 0.
- R5: Entries are ordered by ascending row and then ascending column. A snapshot holds at most 8 entries, and keys beyond the eighth are dropped.
- R6: A key is reported only if its column sample, taken at the end of the 16-tick settle time, stays unchanged for the following debounce ticks (control bits 13:4). A key whose level keeps changing is not reported.
- R7: Reading 0x34 pops the head snapshot and lowers the count by one. Reading 0x30 does not pop. With the FIFO empty, both entry registers read 0.
- R8: Status bits 7:4 give the FIFO count, which never exceeds FIFO_DEPTH. A snapshot that arrives while the FIFO is full is dropped. A pass with no key pressed pushes nothing.
- R9: Status bit 2 is set while the count is at least the threshold (control bits 17:14, nonzero). Writing 1 to the bit clears it, but it sets again at once if the condition still holds. irq_o is high when that bit and the interrupt enable (control bit 3) are both 1.
- R10: The row r mask register sits at 0x38 + 4*r, with bit c for column c. A scanned key whose mask bit is 0 sets status bit 0 and drives wake_o. Writing 1 to status bit 0 clears it. A key with its mask bit set never raises wake.
- R11: Clearing control bit 0 (enable) stops scanning, drives every row high and empties the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scan_tick_i | input | 1 | One-cycle pulse that advances scan timing |
| col_i | input | NUM_COLS | Column sense lines, low when a key in the driven row is pressed |
| row_o | output | NUM_ROWS | Row drive lines, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (carries the pop side effect) |
| reg_addr_i | input | 8 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from the address |
| irq_o | output | 1 | Level interrupt for the FIFO threshold |
| wake_o | output | 1 | Wake request from an unmasked key |

## Verification
The bound checker enforces several rules on every cycle: at most one row is driven, rows stay idle and the FIFO stays empty while the block is disabled, the count never passes the depth, a pop lowers the count by exactly one, the interrupt never rises without its enable, and an empty FIFO reads as zero. Other behaviours can only be shown by the bench's scenarios. These are the byte encoding and ordering for every one of the 128 single-key positions, truncation at eight keys, the exact pass period, rejection of a chattering key, the re-arming of the threshold flag after a clear, and per-key wake masking.

// File: rtl/keypad_pkg.sv
package keypad_pkg;
  localparam int ENTRY_W      = 8;
  localparam int SNAP_KEYS    = 8;
  localparam int SNAP_W       = ENTRY_W * SNAP_KEYS;
  localparam int SETTLE_TICKS = 16;
  localparam int START_TICKS  = 5;
  localparam int DBC_W        = 10;
  localparam int THR_W        = 4;

  localparam logic [7:0] ADDR_CTRL   = 8'h00;
  localparam logic [7:0] ADDR_STAT   = 8'h04;
  localparam logic [7:0] ADDR_GAP    = 8'h2C;
  localparam logic [7:0] ADDR_ENT_LO = 8'h30;
  localparam logic [7:0] ADDR_ENT_HI = 8'h34;
  localparam logic [7:0] ADDR_MASK0  = 8'h38;

  typedef enum logic [1:0] {SC_IDLE, SC_START, SC_ROW, SC_GAP} scan_state_e;

  function automatic logic [ENTRY_W-1:0] make_entry(input logic [3:0] row, input logic [2:0] col);
    return {1'b1, row, col};
  endfunction
endpackage

// File: rtl/kp_row_scanner.sv
module kp_row_scanner
  import keypad_pkg::*;
#(
  parameter int NUM_ROWS = 16,
  parameter int NUM_COLS = 8,
  parameter int GAP_W    = 16,
  localparam int ROW_W   = $clog2(NUM_ROWS),
  localparam int CNT_W   = (GAP_W > 12) ? GAP_W : 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                tick_i,
  input  logic [DBC_W-1:0]    dbc_i,
  input  logic [GAP_W-1:0]    gap_i,
  input  logic [NUM_COLS-1:0] col_ni,
  output logic [NUM_ROWS-1:0] row_no,
  output logic                row_done_o,
  output logic                last_row_o,
  output logic [ROW_W-1:0]    row_idx_o,
  output logic [NUM_COLS-1:0] row_keys_o
);
  scan_state_e         state_q;
  logic [CNT_W-1:0]    cnt_q, win_last;
  logic [ROW_W-1:0]    row_q;
  logic [NUM_COLS-1:0] cap_q, stab_q, pressed;
  logic                win_end;

  assign pressed  = ~col_ni;
  assign win_last = CNT_W'(SETTLE_TICKS) + CNT_W'(dbc_i) - CNT_W'(1);
  assign win_end  = (cnt_q >= win_last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SC_IDLE;
      cnt_q   <= '0;
      row_q   <= '0;
      cap_q   <= '0;
      stab_q  <= '0;
    end else if (!en_i) begin
      state_q <= SC_IDLE;
      cnt_q   <= '0;
      row_q   <= '0;
      cap_q   <= '0;
      stab_q  <= '0;
    end else begin
      case (state_q)
        SC_IDLE: begin
          state_q <= SC_START;
          cnt_q   <= '0;
        end
        SC_START: if (tick_i) begin
          if (cnt_q >= CNT_W'(START_TICKS - 1)) begin
            state_q <= SC_ROW;
            cnt_q   <= '0;
            row_q   <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        SC_ROW: if (tick_i) begin
          if (cnt_q == CNT_W'(SETTLE_TICKS - 1)) begin
            cap_q  <= pressed;
            stab_q <= '1;
          end else if (cnt_q >= CNT_W'(SETTLE_TICKS)) begin
            stab_q <= stab_q & ~(pressed ^ cap_q);
          end
          if (win_end) begin
            cnt_q <= '0;
            if (row_q == ROW_W'(NUM_ROWS - 1)) begin
              row_q   <= '0;
              state_q <= (gap_i == '0) ? SC_START : SC_GAP;
            end else row_q <= row_q + 1'b1;
          end else cnt_q <= cnt_q + 1'b1;
        end
        SC_GAP: if (tick_i) begin
          if ((cnt_q + 1'b1) >= CNT_W'(gap_i)) begin
            state_q <= SC_START;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: state_q <= SC_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_ROWS; g++) begin : g_row_drv
    assign row_no[g] = !((state_q == SC_ROW) && (row_q == ROW_W'(g)));
  end

  assign row_done_o = (state_q == SC_ROW) && tick_i && win_end;
  assign last_row_o = (row_q == ROW_W'(NUM_ROWS - 1));
  assign row_idx_o  = row_q;
  // with zero debounce the settle sample is the result
  assign row_keys_o = (dbc_i == '0) ? pressed : (cap_q & stab_q & ~(pressed ^ cap_q));
endmodule

// File: rtl/kp_snap_packer.sv
module kp_snap_packer
  import keypad_pkg::*;
#(
  parameter int NUM_COLS = 8,
  parameter int ROW_W    = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clear_i,
  input  logic                row_done_i,
  input  logic                last_row_i,
  input  logic [ROW_W-1:0]    row_idx_i,
  input  logic [NUM_COLS-1:0] row_keys_i,
  output logic                push_o,
  output logic [SNAP_W-1:0]   snap_o
);
  logic [SNAP_W-1:0] acc_q, acc_d, snap_q;
  logic [3:0]        n_q, n_d;
  logic              push_q;

  always_comb begin
    int n;
    acc_d = acc_q;
    n     = int'(n_q);
    for (int c = 0; c < NUM_COLS; c++) begin
      if (row_keys_i[c] && n < SNAP_KEYS) begin
        acc_d[n*ENTRY_W +: ENTRY_W] = make_entry(4'(row_idx_i), 3'(c));
        n++;
      end
    end
    n_d = 4'(n);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      n_q    <= '0;
      push_q <= 1'b0;
      snap_q <= '0;
    end else if (clear_i) begin
      acc_q  <= '0;
      n_q    <= '0;
      push_q <= 1'b0;
    end else begin
      push_q <= 1'b0;
      if (row_done_i) begin
        if (last_row_i) begin
          push_q <= (n_d != '0);
          snap_q <= acc_d;
          acc_q  <= '0;
          n_q    <= '0;
        end else begin
          acc_q <= acc_d;
          n_q   <= n_d;
        end
      end
    end
  end

  assign push_o = push_q;
  assign snap_o = snap_q;
endmodule

// File: rtl/kp_entry_fifo.sv
module kp_entry_fifo #(
  parameter int DEPTH  = 4,
  parameter int W      = 64,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             push_i,
  input  logic [W-1:0]     data_i,
  input  logic             pop_i,
  output logic [W-1:0]     head_o,
  output logic [CNT_W-1:0] count_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign do_pop  = pop_i && (cnt_q != '0);
  assign do_push = push_i && (cnt_q != CNT_W'(DEPTH));

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (clear_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) begin
        mem_q[wr_q] <= data_i;
        wr_q        <= nxt(wr_q);
      end
      if (do_pop) rd_q <= nxt(rd_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign head_o  = (cnt_q == '0) ? '0 : mem_q[rd_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/keypad_scan_top.sv
module keypad_scan_top
  import keypad_pkg::*;
#(
  parameter int NUM_ROWS   = 16,
  parameter int NUM_COLS   = 8,
  parameter int FIFO_DEPTH = 4,
  parameter int GAP_W      = 16,
  localparam int ROW_W     = $clog2(NUM_ROWS),
  localparam int FCNT_W    = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                scan_tick_i,
  input  logic [NUM_COLS-1:0] col_i,
  output logic [NUM_ROWS-1:0] row_o,
  input  logic                reg_we_i,
  input  logic                reg_re_i,
  input  logic [7:0]          reg_addr_i,
  input  logic [31:0]         reg_wdata_i,
  output logic [31:0]         reg_rdata_o,
  output logic                irq_o,
  output logic                wake_o
);
  logic                en_q, ie_q, thr_flag_q, wake_flag_q;
  logic [DBC_W-1:0]    dbc_q;
  logic [THR_W-1:0]    thr_q;
  logic [GAP_W-1:0]    gap_q;
  logic [NUM_COLS-1:0] mask_q [NUM_ROWS];
  logic [NUM_ROWS-1:0] mask_sel;

  logic                row_done, last_row, push, pop;
  logic [ROW_W-1:0]    row_idx;
  logic [NUM_COLS-1:0] row_keys;
  logic [SNAP_W-1:0]   snap, head;
  logic [FCNT_W-1:0]   fifo_cnt;
  logic                thr_hit, wake_hit, wr_ctrl, wr_stat, wr_gap;
  logic                unused_wdata;

  assign unused_wdata = ^reg_wdata_i[31:18];

  kp_row_scanner #(.NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS), .GAP_W(GAP_W)) u_scan (
    .clk_i, .rst_ni,
    .en_i       (en_q),
    .tick_i     (scan_tick_i),
    .dbc_i      (dbc_q),
    .gap_i      (gap_q),
    .col_ni     (col_i),
    .row_no     (row_o),
    .row_done_o (row_done),
    .last_row_o (last_row),
    .row_idx_o  (row_idx),
    .row_keys_o (row_keys)
  );

  kp_snap_packer #(.NUM_COLS(NUM_COLS), .ROW_W(ROW_W)) u_pack (
    .clk_i, .rst_ni,
    .clear_i    (!en_q),
    .row_done_i (row_done),
    .last_row_i (last_row),
    .row_idx_i  (row_idx),
    .row_keys_i (row_keys),
    .push_o     (push),
    .snap_o     (snap)
  );

  kp_entry_fifo #(.DEPTH(FIFO_DEPTH), .W(SNAP_W)) u_fifo (
    .clk_i, .rst_ni,
    .clear_i (!en_q),
    .push_i  (push),
    .data_i  (snap),
    .pop_i   (pop),
    .head_o  (head),
    .count_o (fifo_cnt)
  );

  assign pop     = reg_re_i && (reg_addr_i == ADDR_ENT_HI);
  assign wr_ctrl = reg_we_i && (reg_addr_i == ADDR_CTRL);
  assign wr_stat = reg_we_i && (reg_addr_i == ADDR_STAT);
  assign wr_gap  = reg_we_i && (reg_addr_i == ADDR_GAP);
  assign thr_hit = (thr_q != '0) && (32'(fifo_cnt) >= 32'(thr_q));
  assign wake_hit = row_done && |(row_keys & ~mask_q[row_idx]);

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_mask_dec
    assign mask_sel[r] = (reg_addr_i == ADDR_MASK0 + 8'(4 * r));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      ie_q  <= 1'b0;
      dbc_q <= '0;
      thr_q <= '0;
      gap_q <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q  <= reg_wdata_i[0];
        ie_q  <= reg_wdata_i[3];
        dbc_q <= reg_wdata_i[13:4];
        thr_q <= reg_wdata_i[17:14];
      end
      if (wr_gap) gap_q <= reg_wdata_i[GAP_W-1:0];
    end
  end

  // set dominates clear so a still-true condition re-arms at once
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_flag_q  <= 1'b0;
      wake_flag_q <= 1'b0;
    end else begin
      thr_flag_q  <= (thr_flag_q  & ~(wr_stat & reg_wdata_i[2])) | thr_hit;
      wake_flag_q <= (wake_flag_q & ~(wr_stat & reg_wdata_i[0])) | wake_hit;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < NUM_ROWS; r++) mask_q[r] <= '1;
    end else if (reg_we_i) begin
      for (int r = 0; r < NUM_ROWS; r++)
        if (mask_sel[r]) mask_q[r] <= reg_wdata_i[NUM_COLS-1:0];
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      ADDR_CTRL: begin
        reg_rdata_o[0]     = en_q;
        reg_rdata_o[3]     = ie_q;
        reg_rdata_o[13:4]  = dbc_q;
        reg_rdata_o[17:14] = thr_q;
      end
      ADDR_STAT: begin
        reg_rdata_o[0]   = wake_flag_q;
        reg_rdata_o[2]   = thr_flag_q;
        reg_rdata_o[7:4] = 4'(fifo_cnt);
      end
      ADDR_GAP:    reg_rdata_o[GAP_W-1:0] = gap_q;
      ADDR_ENT_LO: reg_rdata_o = head[31:0];
      ADDR_ENT_HI: reg_rdata_o = head[63:32];
      default: begin
        for (int r = 0; r < NUM_ROWS; r++)
          if (mask_sel[r]) reg_rdata_o[NUM_COLS-1:0] = mask_q[r];
      end
    endcase
  end

  assign irq_o  = thr_flag_q & ie_q;
  assign wake_o = wake_flag_q;
endmodule

// File: rtl/kp_checker.sv
module kp_checker #(
  parameter int NUM_ROWS   = 16,
  parameter int FIFO_DEPTH = 4,
  parameter int FCNT_W     = 3
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [NUM_ROWS-1:0] row_o,
  input logic                en_i,
  input logic                ie_i,
  input logic                irq_o,
  input logic                push_i,
  input logic                pop_i,
  input logic [FCNT_W-1:0]   count_i,
  input logic                re_i,
  input logic [7:0]          addr_i,
  input logic [31:0]         rdata_i
);
  assert_one_row_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~row_o));

  assert_rows_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (row_o == '1));

  assert_flush_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (count_i == '0));

  assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(count_i) <= FIFO_DEPTH);

  assert_pop_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && pop_i && !push_i && count_i != '0) |=> (count_i == $past(count_i) - 1'b1));

  assert_empty_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && count_i == '0 && (addr_i == 8'h30 || addr_i == 8'h34)) |-> (rdata_i == '0));

  assert_irq_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ie_i);
endmodule

bind keypad_scan_top kp_checker #(
  .NUM_ROWS(NUM_ROWS), .FIFO_DEPTH(FIFO_DEPTH), .FCNT_W(FCNT_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .row_o   (row_o),
  .en_i    (en_q),
  .ie_i    (ie_q),
  .irq_o   (irq_o),
  .push_i  (push),
  .pop_i   (pop),
  .count_i (fifo_cnt),
  .re_i    (reg_re_i),
  .addr_i  (reg_addr_i),
  .rdata_i (reg_rdata_o)
);

// File: tb/sim_keypad_scan_top.sv
module sim_keypad_scan_top;
  localparam int NR = 16;
  localparam int NC = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b1;
  logic [NC-1:0] col;
  logic [NR-1:0] row;
  logic          we = 1'b0, re = 1'b0;
  logic [7:0]    addr = '0;
  logic [31:0]   wdata = '0, rdata;
  logic          irq, wake;

  logic [NR*NC-1:0] keys = '0;
  logic             chat_en = 1'b0, chat_q = 1'b0;
  int               chat_idx = 0;

  int checks = 0, errors = 0, cyc = 0;
  int row_viol = 0, prev_row = -1;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (chat_en) chat_q <= ~chat_q;

  keypad_scan_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .scan_tick_i(tick), .col_i(col), .row_o(row),
    .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq), .wake_o(wake)
  );

  always_comb begin
    for (int c = 0; c < NC; c++) begin
      col[c] = 1'b1;
      for (int r = 0; r < NR; r++) begin
        if (!row[r] && (keys[r*NC+c] || (chat_en && chat_idx == r*NC+c && chat_q)))
          col[c] = 1'b0;
      end
    end
  end

  // R2 monitor: single active row, stepping upward
  always @(negedge clk) if (rst_n) begin
    int zeros, idx;
    zeros = 0; idx = -1;
    for (int r = 0; r < NR; r++) if (!row[r]) begin zeros++; idx = r; end
    if (zeros > 1) row_viol++;
    if (idx >= 0 && idx != prev_row) begin
      if (!(idx == 0 || idx == prev_row + 1)) row_viol++;
      prev_row = idx;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk); #1 we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; re = 1'b1;
    #1 d = rdata;
    @(posedge clk); #1 re = 1'b0;
  endtask

  function automatic logic [31:0] ctrl_word(input bit en, input bit ie, input int dbc, input int thr);
    return 32'(en) | (32'(ie) << 3) | (32'(dbc) << 4) | (32'(thr) << 14);
  endfunction

  function automatic logic [63:0] exp_snap(input logic [NR*NC-1:0] k);
    logic [63:0] s;
    int n;
    s = '0; n = 0;
    for (int r = 0; r < NR; r++)
      for (int c = 0; c < NC; c++)
        if (k[r*NC+c] && n < 8) begin
          s[n*8 +: 8] = {1'b1, 4'(r), 3'(c)};
          n++;
        end
    return s;
  endfunction

  task automatic get_count(output int n);
    logic [31:0] d;
    rd(8'h04, d);
    n = int'(d[7:4]);
  endtask

  task automatic wait_count(input int target, input int limit, input string req);
    int n;
    n = -1;
    for (int i = 0; i < limit && n != target; i++) get_count(n);
    if (n != target) chk(req, 64'(n), 64'(target));
  endtask

  task automatic read_snap(output logic [63:0] s);
    logic [31:0] lo, hi;
    rd(8'h30, lo);
    rd(8'h34, hi);
    s = {hi, lo};
  endtask

  task automatic restart(input logic [31:0] ctrl);
    wr(8'h00, 32'h0);
    wr(8'h00, ctrl);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [63:0] s;
    int n, t1, t2;

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 rows", 64'(row), 64'(16'hFFFF));
    chk("R1 irq", 64'(irq), 64'd0);
    chk("R1 wake", 64'(wake), 64'd0);
    rd(8'h00, d); chk("R1 ctrl", 64'(d), 64'd0);
    rd(8'h04, d); chk("R1 status", 64'(d), 64'd0);
    read_snap(s); chk("R1 entries", s, 64'd0);
    rd(8'h38, d); chk("R1 mask row0", 64'(d), 64'hFF);
    rd(8'h74, d); chk("R1 mask row15", 64'(d), 64'hFF);

    // R4 sweep: every single key position
    wr(8'h2C, 32'd0);
    for (int k = 0; k < NR*NC; k++) begin
      keys = '0; keys[k] = 1'b1;
      restart(ctrl_word(1, 0, 0, 0));
      wait_count(1, 2000, "R4 sweep push");
      read_snap(s);
      chk($sformatf("R4 key r%0d c%0d", k / NC, k % NC), s, 64'(8'h80 | k));
    end

    // R5 ordering and truncation to 8 keys
    keys = '0;
    keys[15*NC+7] = 1; keys[0*NC+6] = 1; keys[12*NC+5] = 1; keys[2*NC+0] = 1;
    keys[5*NC+4] = 1;  keys[0*NC+1] = 1; keys[9*NC+2] = 1;  keys[5*NC+3] = 1;
    keys[14*NC+0] = 1; keys[7*NC+7] = 1;
    restart(ctrl_word(1, 0, 0, 0));
    wait_count(1, 2000, "R5 push");
    read_snap(s);
    chk("R5 order and truncation", s, exp_snap(keys));
    chk("R5 entry0 is r0 c1", 64'(s[7:0]), 64'h81);

    // R3 pass period with debounce 3 and gap 7
    keys = '0; keys[4*NC+1] = 1'b1;
    wr(8'h2C, 32'd7);
    restart(ctrl_word(1, 0, 3, 0));
    wait_count(1, 2000, "R3 first push");
    t1 = cyc;
    wait_count(2, 2000, "R3 second push");
    t2 = cyc;
    chk("R3 period", 64'(t2 - t1), 64'(5 + NR * (16 + 3) + 7));

    // R8 FIFO fills to depth and holds there
    repeat (4 * 316) @(posedge clk);
    get_count(n); chk("R8 count at depth", 64'(n), 64'd4);
    // R7 low read keeps, high read pops
    rd(8'h30, d); chk("R7 low word", 64'(d), 64'h0000_0000_0000_00A1);
    get_count(n); chk("R7 no pop on low read", 64'(n), 64'd4);
    rd(8'h34, d);
    get_count(n); chk("R7 pop on high read", 64'(n), 64'd3);

    // R11 disable flushes and idles rows
    wr(8'h00, 32'h0);
    @(negedge clk);
    chk("R11 rows idle", 64'(row), 64'(16'hFFFF));
    get_count(n); chk("R11 flushed", 64'(n), 64'd0);
    read_snap(s); chk("R7 empty reads zero", s, 64'd0);

    // R8 nothing pressed, nothing pushed
    keys = '0;
    wr(8'h2C, 32'd0);
    wr(8'h00, ctrl_word(1, 0, 0, 0));
    repeat (700) @(posedge clk);
    get_count(n); chk("R8 no push without keys", 64'(n), 64'd0);

    // R6 chattering key is rejected, steady key kept
    keys = '0; keys[2*NC+2] = 1'b1;
    chat_idx = 2*NC+6; chat_en = 1'b1;
    restart(ctrl_word(1, 0, 3, 0));
    wait_count(1, 2000, "R6 push");
    read_snap(s);
    chk("R6 chatter rejected", s, 64'(8'h92));
    chat_en = 1'b0;

    // R9 threshold flag and interrupt
    keys = '0; keys[1*NC+1] = 1'b1;
    wr(8'h2C, 32'd2000);
    restart(ctrl_word(1, 1, 0, 2));
    wait_count(1, 3000, "R9 first push");
    rd(8'h04, d); chk("R9 below threshold flag", 64'(d[2]), 64'd0);
    chk("R9 below threshold irq", 64'(irq), 64'd0);
    wait_count(2, 3000, "R9 second push");
    rd(8'h04, d); chk("R9 at threshold flag", 64'(d[2]), 64'd1);
    chk("R9 irq high", 64'(irq), 64'd1);
    wr(8'h04, 32'h4);
    rd(8'h04, d); chk("R9 re-arms while met", 64'(d[2]), 64'd1);
    read_snap(s);
    wr(8'h04, 32'h4);
    rd(8'h04, d); chk("R9 cleared below threshold", 64'(d[2]), 64'd0);
    chk("R9 irq low after clear", 64'(irq), 64'd0);

    // R10 per-key wake masking
    wr(8'h00, 32'h0);
    wr(8'h2C, 32'd0);
    wr(8'h38 + 8'd12, 32'hDF);
    rd(8'h38 + 8'd12, d); chk("R10 mask readback", 64'(d), 64'hDF);
    keys = '0; keys[3*NC+5] = 1'b1;
    wr(8'h04, 32'h7);
    wr(8'h00, ctrl_word(1, 0, 0, 0));
    wait_count(1, 2000, "R10 push");
    chk("R10 wake unmasked key", 64'(wake), 64'd1);
    rd(8'h04, d); chk("R10 wake status", 64'(d[0]), 64'd1);
    keys = '0;
    repeat (300) @(posedge clk);
    wr(8'h04, 32'h1);
    repeat (300) @(posedge clk);
    chk("R10 wake cleared", 64'(wake), 64'd0);
    keys[3*NC+4] = 1'b1;
    restart(ctrl_word(1, 0, 0, 0));
    wait_count(1, 2000, "R10 masked push");
    repeat (10) @(posedge clk);
    chk("R10 masked key no wake", 64'(wake), 64'd0);

    chk("R2 row order violations", 64'(row_viol), 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule